// File: doc/BRIEF.md
# Pipelined Multiply-Add Datapath

This block computes `a * b + c` on a continuous stream of unsigned integer operand triples. It has three register segments, and every pipeline register loads on every clock edge. The first segment captures the two multiplicands. The second segment registers their full-width product and, on the same edge, captures the addend. The third segment registers the sum, and that sum drives the `result` port. Once the pipe is full, the block accepts a new triple on every clock and delivers a new result on every clock.

A valid bit travels next to the data through three flops. The surrounding logic can therefore pair each result with the operands that produced it. A synchronous reset clears the valid bits only; the data registers may hold stale values while nothing valid is inside them.

The addend enters one segment later than the multiplicands. In the default lagged mode, the caller presents the `c` of an item one clock after that item's `a`/`b`. In the aligned mode, an internal delay flop realigns a `c` that arrives together with `a`/`b`.

The product register is `2W` bits wide and the sum register is `2W+1` bits wide.

Segment names used in the code are CAPTURE (segment 1), PRODUCT (segment 2) and SUM (segment 3). The only transition is the unconditional advance of each segment into the next one on every clock.

Top module: `madd_pipe`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_valid` is 0. Items that were in flight when reset was applied never produce an `out_valid` pulse.
- R2: `out_valid` is high exactly three clocks after the clock in which `in_valid` was sampled high, and low otherwise.
- R3: `result` equals the unsigned value `a*b + c` in full `2W+1`-bit width, with no wrap. This includes the case `a = b = c = 2^W-1`; with the default `W = 8` that case gives 65280, and bit `2W` is then 0.
- R4: In the default lagged mode, the `c` used for an item is the value on `c_in` one clock after the clock in which that item's `a_in`/`b_in` were sampled.
- R5: With `n` items on consecutive clocks, the results appear on `n` consecutive clocks, and the last one appears `3 + (n-1)` clocks after the first item was sampled.
- R6: Gaps in `in_valid` reappear as gaps of the same length and position in `out_valid`. Operand values presented while `in_valid` is low do not alter the results of the valid items around them.
- R7: All pipeline data registers load every clock with no enable. The latency is therefore fixed and does not depend on the input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the valid bits |
| in_valid | input | 1 | Marks `a_in`/`b_in` in this clock as a real item |
| a_in | input | W | First multiplicand, unsigned |
| b_in | input | W | Second multiplicand, unsigned |
| c_in | input | W | Addend; one clock after `a_in`/`b_in` in lagged mode |
| out_valid | output | 1 | `result` holds the sum of a valid item |
| result | output | 2W+1 | `a*b + c` of the item three clocks earlier |

## Verification
Each result is due exactly three clocks after its multiplicands are sampled, and its addend is due two clocks before that result. When the driver launches an item, it stamps the item's expected value with the cycle number plus three. The monitor then samples on the falling edge and requires the head of the queue to emerge in exactly that cycle. A result that comes early, comes late, is missing or was never requested is reported against R2 or R5. Distinct `c` values on adjacent items make a one-clock misalignment of the addend visible as a wrong sum.

// File: rtl/madd_pkg.sv
package madd_pkg;

    // Number of register segments from operand capture to result.
    localparam int unsigned SEGMENTS = 3;

    // How the addend arrives relative to its multiplicands.
    typedef enum logic {
        ADDEND_ALIGNED = 1'b0,
        ADDEND_LAGGED  = 1'b1
    } addend_mode_e;

endpackage

// File: rtl/madd_seg_capture.sv
// Segment CAPTURE: registers both multiplicands every clock.
module madd_seg_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);

    always_ff @(posedge clk) begin
        a_q <= a_in;
        b_q <= b_in;
    end

endmodule

// File: rtl/madd_seg_product.sv
// Segment PRODUCT: full-width product plus addend capture.
module madd_seg_product #(
    parameter int unsigned          W      = 8,
    parameter madd_pkg::addend_mode_e C_MODE = madd_pkg::ADDEND_LAGGED
) (
    input  logic           clk,
    input  logic [W-1:0]   a_q,
    input  logic [W-1:0]   b_q,
    input  logic [W-1:0]   c_in,
    output logic [2*W-1:0] prod_q,
    output logic [W-1:0]   addend_q
);

    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  c_src;
    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;

    generate
        if (C_MODE == madd_pkg::ADDEND_LAGGED) begin : g_lagged
            assign c_src = c_in;
        end else begin : g_aligned
            logic [W-1:0] c_dly;
            always_ff @(posedge clk) begin
                c_dly <= c_in;
            end
            assign c_src = c_dly;
        end
    endgenerate

    assign a_ext = {{W{1'b0}}, a_q};
    assign b_ext = {{W{1'b0}}, b_q};

    always_ff @(posedge clk) begin
        prod_q   <= a_ext * b_ext;
        addend_q <= c_src;
    end

endmodule

// File: rtl/madd_seg_sum.sv
// Segment SUM: adds addend to product into a one-bit-wider register.
module madd_seg_sum #(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic [2*W-1:0] prod_q,
    input  logic [W-1:0]   addend_q,
    output logic [2*W:0]   sum_q
);

    localparam int unsigned SW = 2 * W + 1;

    logic [SW-1:0] prod_ext;
    logic [SW-1:0] addend_ext;

    assign prod_ext   = {1'b0, prod_q};
    assign addend_ext = {{(W + 1){1'b0}}, addend_q};

    always_ff @(posedge clk) begin
        sum_q <= prod_ext + addend_ext;
    end

endmodule

// File: rtl/madd_valid_track.sv
// Valid bit shadowing the data segments; the only reset state in the block.
module madd_valid_track #(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic out_valid
);

    logic [DEPTH-1:0] stage_v;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_v[k] <= 1'b0;
                    else     stage_v[k] <= in_valid;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage_v[k] <= 1'b0;
                    else     stage_v[k] <= stage_v[k-1];
                end

                AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (rst)
                    stage_v[k] |-> $past(stage_v[k-1])); // R2
            end
        end
    endgenerate

    assign out_valid = stage_v[DEPTH-1];

    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stage_v == '0)); // R1

endmodule

// File: rtl/madd_pipe.sv
// Three-segment multiply-add pipe: result = a*b + c.
module madd_pipe #(
    parameter int unsigned            W      = 8,
    parameter madd_pkg::addend_mode_e C_MODE = madd_pkg::ADDEND_LAGGED
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [W-1:0]   c_in,
    output logic           out_valid,
    output logic [2*W:0]   result
);

    localparam int unsigned PW    = 2 * W;
    localparam int unsigned RW    = 2 * W + 1;
    localparam int unsigned DEPTH = madd_pkg::SEGMENTS;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic [PW-1:0] prod_q;
    logic [W-1:0]  addend_q;

    madd_seg_capture #(.W(W)) u_capture (
        .clk  (clk),
        .a_in (a_in),
        .b_in (b_in),
        .a_q  (a_q),
        .b_q  (b_q)
    );

    madd_seg_product #(.W(W), .C_MODE(C_MODE)) u_product (
        .clk      (clk),
        .a_q      (a_q),
        .b_q      (b_q),
        .c_in     (c_in),
        .prod_q   (prod_q),
        .addend_q (addend_q)
    );

    madd_seg_sum #(.W(W)) u_sum (
        .clk      (clk),
        .prod_q   (prod_q),
        .addend_q (addend_q),
        .sum_q    (result)
    );

    madd_valid_track #(.DEPTH(DEPTH)) u_valid (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    // Checking aids: cycles since reset, and an independent arithmetic reference.
    logic [CW-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst)                        settle_cnt <= '0;
        else if (settle_cnt != CW'(DEPTH)) settle_cnt <= settle_cnt + 1'b1;
    end

    function automatic logic [RW-1:0] madd_ref(logic [W-1:0] a, logic [W-1:0] b,
                                               logic [W-1:0] c);
        logic [RW-1:0] prod;
        prod = RW'(a) * RW'(b);
        return prod + RW'(c);
    endfunction

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (settle_cnt == CW'(DEPTH)) |-> (out_valid == $past(in_valid, 3))); // R2

    generate
        if (C_MODE == madd_pkg::ADDEND_LAGGED) begin : g_chk_lagged
            AST_RESULT_VALUE: assert property (@(posedge clk) disable iff (rst)
                ((settle_cnt == CW'(DEPTH)) && out_valid) |->
                (result == madd_ref($past(a_in, 3), $past(b_in, 3), $past(c_in, 2)))); // R4
        end else begin : g_chk_aligned
            AST_RESULT_VALUE: assert property (@(posedge clk) disable iff (rst)
                ((settle_cnt == CW'(DEPTH)) && out_valid) |->
                (result == madd_ref($past(a_in, 3), $past(b_in, 3), $past(c_in, 3)))); // R4
        end
    endgenerate

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result[RW-1] == 1'b0)); // R3

endmodule

// File: tb/tb_madd_pipe.sv
module tb_madd_pipe;

    localparam int unsigned W  = 8;
    localparam int unsigned RW = 2 * W + 1;
    localparam int unsigned LAT = 3;

    typedef struct {
        logic [RW-1:0] val;
        int            due;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic [W-1:0]  c_in = '0;
    logic          out_valid;
    logic [RW-1:0] result;

    int     cyc = 0;
    int     n_checks = 0;
    int     n_errors = 0;
    logic [W-1:0] c_hold = '0;
    exp_t   sb[$];
    bit     finished = 1'b0;

    madd_pipe #(.W(W), .C_MODE(madd_pkg::ADDEND_LAGGED)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .c_in      (c_in),
        .out_valid (out_valid),
        .result    (result)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, bit ok, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver: one slot per clock; c of the previous slot goes out now (R4 lag).
    task automatic slot(bit v, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, string req);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        a_in     = a;
        b_in     = b;
        c_in     = c_hold;
        c_hold   = c;
        if (v) begin
            e.val = RW'(a) * RW'(b) + RW'(c);
            e.due = cyc + LAT;
            e.req = req;
            sb.push_back(e);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) slot(1'b0, 8'hA5, 8'h5A, 8'h33, "");
    endtask

    // Monitor: compares value and arrival cycle of each result.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R2", 1'b0, "unexpected out_valid", RW'(1), RW'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, result == e.val, "result value", result, e.val);
                    check("R5", cyc == e.due, "result cycle", RW'(cyc), RW'(e.due));
                end
            end else if (sb.size() > 0 && sb[0].due <= cyc) begin
                check("R2", 1'b0, "missing out_valid at due cycle", RW'(0), RW'(1));
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #(4 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", out_valid == 1'b0, "out_valid during reset", RW'(out_valid), RW'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R1", out_valid == 1'b0, "out_valid first clock after reset", RW'(out_valid), RW'(0));
        idle(3);

        // R3: single item, then the all-ones corner
        slot(1'b1, 8'd7, 8'd9, 8'd5, "R3");
        idle(4);
        slot(1'b1, 8'hFF, 8'hFF, 8'hFF, "R3");
        idle(4);
        slot(1'b1, 8'd0, 8'd200, 8'd0, "R3");
        idle(4);

        // R5: eight back-to-back items
        for (int i = 0; i < 8; i++)
            slot(1'b1, 8'(3 * i + 1), 8'(250 - 7 * i), 8'(17 * i + 2), "R5");
        idle(5);

        // R4: adjacent items with very different addends
        slot(1'b1, 8'd1, 8'd1, 8'd200, "R4");
        slot(1'b1, 8'd1, 8'd1, 8'd3,   "R4");
        slot(1'b1, 8'd2, 8'd2, 8'd100, "R4");
        slot(1'b1, 8'd0, 8'd0, 8'd77,  "R4");
        idle(5);

        // R6/R7: bubbles with junk operands between valid items
        slot(1'b1, 8'd11, 8'd13, 8'd1,  "R6");
        slot(1'b0, 8'hFF, 8'hFF, 8'hFF, "");
        slot(1'b1, 8'd21, 8'd4,  8'd9,  "R6");
        slot(1'b0, 8'h80, 8'h80, 8'h80, "");
        slot(1'b0, 8'h01, 8'hFE, 8'h44, "");
        slot(1'b1, 8'd99, 8'd2,  8'd250, "R7");
        slot(1'b1, 8'd128, 8'd2, 8'd1,  "R7");
        idle(5);

        // R1: reset mid-stream drops in-flight items
        slot(1'b1, 8'd5, 8'd5, 8'd5, "R1");
        slot(1'b1, 8'd6, 8'd6, 8'd6, "R1");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        sb.delete();
        @(negedge clk);
        check("R1", out_valid == 1'b0, "out_valid during mid-stream reset", RW'(out_valid), RW'(0));
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", out_valid == 1'b0, "flushed item re-emerged", RW'(out_valid), RW'(0));
        end

        // R2: resume after reset
        slot(1'b1, 8'd12, 8'd12, 8'd12, "R2");
        idle(5);
        check("R2", sb.size() == 0, "scoreboard drained", RW'(sb.size()), RW'(0));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule